// File: doc/BRIEF.md
# Read-After-Write Interlock and Bypass Select Unit

This unit sits beside the decode stage of a five-stage in-order integer pipeline (fetch, decode with register read, execute, memory, write-back). Each cycle it looks at the instruction word being decoded and at the destination register and write flags of the three older instructions in execute, memory and write-back. From these it works out where each of the two ALU operands of the decoding instruction should be taken from once that instruction reaches execute. When the value does not exist yet, it requests a one-cycle interlock.

Registers are read only in decode and written only in write-back, so write-after-read and write-after-write orderings cannot be violated. Only true read-after-write dependences are tracked. The one dependence that bypassing cannot cover is a load in execute whose result is needed by the instruction right behind it. That case freezes the program counter and the fetch/decode register and sends an empty slot into execute. One cycle later the load sits in memory, and the value is taken from the memory/write-back result. The unit also produces the control fields that the decoding instruction carries into the execute stage, and clears them when it sends an empty slot.

Top module: `hazard_interlock`

## Requirements
- R1: Operand fields sit at fixed bit positions. The opcode is bits 31:26 and the first source is bits 25:21. In register-register format the second source is bits 20:16 and the destination is bits 15:11. In register-immediate format the destination is bits 20:16.
- R2: Opcode 0x00 is register-register and reads both sources. Opcode 0x2B (store) and opcodes 0x04/0x05 (branch) read both sources and write nothing. Opcode 0x23 (load) reads the first source and writes bits 20:16. Opcodes 0x02/0x03 (jump) read and write nothing. Every other opcode is register-immediate and reads only the first source.
- R3: For each operand the select picks the newest writer of that register: 1 for the execute-stage result, else 2 for the memory-stage result, else 3 for the write-back value, else 0 for the register file.
- R4: Register 0 is never a hazard source or a bypass target. A source of 0 selects 0, a writer with destination 0 never matches, and a decoded destination of 0 gives an execute-stage write flag of 0.
- R5: If the execute-stage instruction is a load with its write flag set and a nonzero destination that equals a source the decoding instruction reads, both the hold output and the flush output are 1.
- R6: While flushing, the execute-stage destination, write and load fields are 0 and both operand selects are 0.
- R7: A bit field that the instruction's format does not read as a source never causes a bypass or an interlock.
- R8: A load in the memory stage never causes an interlock. Its result is selected with code 2, so a load-use dependence costs exactly one stalled cycle.
- R9: A stage whose write flag is 0 is ignored for both bypassing and interlock, whatever its load flag says.
- R10: Without a flush, the execute-stage fields carry the decoded destination (per R1), the write flag (set for register-register, register-immediate and load) and the load flag (set only for load).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the property checker |
| rst_n | input | 1 | Active-low reset, used by the property checker |
| id_instr | input | 32 | Instruction word in decode |
| ex_dst | input | 5 | Destination register of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | 5 | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | 5 | Destination register of the write-back instruction |
| wb_wen | input | 1 | Write-back instruction writes a register |
| fwd_a_sel | output | 2 | Source select for ALU operand A (0 file, 1 ex/mem, 2 mem/wb, 3 write-back) |
| fwd_b_sel | output | 2 | Source select for ALU operand B, same encoding |
| pc_hold | output | 1 | Freeze the program counter and the fetch/decode register |
| idex_flush | output | 1 | Load an empty slot into the decode/execute register |
| idex_dst_d | output | 5 | Destination field for the decode/execute register |
| idex_wen_d | output | 1 | Write flag for the decode/execute register |
| idex_load_d | output | 1 | Load flag for the decode/execute register |

## Verification
On every cycle the properties check the following. An interlock only appears with a writing load in execute. A flush always leaves clean control fields and register-file selects. A source of register 0, and every jump, leave all selects at the register file. An execute-stage bypass is only chosen for a matching, writing instruction. The bench scenarios are needed for the rest: the priority order among three matching stages, the per-format choice of which fields count as sources, the decoded destination positions, and the two-cycle sequence in which a load-use interlock turns into a memory/write-back bypass.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int REG_AW = 5;
    localparam int OP_W   = 6;
    localparam int INS_W  = 32;

    // field positions
    localparam int OP_LSB = 26;
    localparam int S1_LSB = 21;
    localparam int S2_LSB = 16;
    localparam int RD_LSB = 11;

    localparam logic [OP_W-1:0] OPC_RR    = 6'h00;
    localparam logic [OP_W-1:0] OPC_JMP   = 6'h02;
    localparam logic [OP_W-1:0] OPC_CALL  = 6'h03;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OPC_BNE   = 6'h05;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;

    typedef logic [REG_AW-1:0] reg_t;

    typedef enum logic [1:0] {
        SRC_RF    = 2'd0,
        SRC_EXMEM = 2'd1,
        SRC_MEMWB = 2'd2,
        SRC_WB    = 2'd3
    } fwd_e;

    typedef struct packed {
        reg_t s1;
        reg_t s2;
        logic u1;
        logic u2;
        reg_t dst;
        logic wen;
        logic load;
    } dec_t;

    typedef struct packed {
        fwd_e sel_a;
        fwd_e sel_b;
        logic stall;
        reg_t dst;
        logic wen;
        logic load;
    } hz_t;

endpackage

// File: rtl/id_field_decode.sv
module id_field_decode
    import hzd_pkg::*;
(
    input  logic [INS_W-1:0] instr,
    output dec_t             dec
);
    logic [OP_W-1:0] op;
    assign op = instr[OP_LSB +: OP_W];

    always_comb begin
        dec      = '0;
        dec.s1   = instr[S1_LSB +: REG_AW];
        dec.s2   = instr[S2_LSB +: REG_AW];
        case (op)
            OPC_RR: begin
                dec.u1  = 1'b1;
                dec.u2  = 1'b1;
                dec.dst = instr[RD_LSB +: REG_AW];
                dec.wen = 1'b1;
            end
            OPC_STORE, OPC_BEQ, OPC_BNE: begin
                dec.u1 = 1'b1;
                dec.u2 = 1'b1;
            end
            OPC_LOAD: begin
                dec.u1   = 1'b1;
                dec.dst  = instr[S2_LSB +: REG_AW];
                dec.wen  = 1'b1;
                dec.load = 1'b1;
            end
            OPC_JMP, OPC_CALL: begin
                dec.u1 = 1'b0;
            end
            default: begin
                dec.u1  = 1'b1;
                dec.dst = instr[S2_LSB +: REG_AW];
                dec.wen = 1'b1;
            end
        endcase
        // r0 is a sink: never a live destination
        if (dec.dst == '0) dec.wen = 1'b0;
        if (dec.dst == '0) dec.load = 1'b0;
    end
endmodule

// File: rtl/operand_bypass_pick.sv
module operand_bypass_pick
    import hzd_pkg::*;
(
    input  reg_t src,
    input  logic used,
    input  reg_t ex_dst,
    input  logic ex_wen,
    input  logic ex_load,
    input  reg_t mem_dst,
    input  logic mem_wen,
    input  reg_t wb_dst,
    input  logic wb_wen,
    output fwd_e sel,
    output logic load_hit
);
    logic live;
    assign live = used && (src != '0);

    always_comb begin
        sel      = SRC_RF;
        load_hit = 1'b0;
        if (live && ex_wen && (ex_dst == src)) begin
            sel      = SRC_EXMEM;
            load_hit = ex_load;
        end else if (live && mem_wen && (mem_dst == src)) begin
            sel = SRC_MEMWB;
        end else if (live && wb_wen && (wb_dst == src)) begin
            sel = SRC_WB;
        end
    end
endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
    import hzd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INS_W-1:0]  id_instr,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              ex_wen,
    input  logic              ex_load,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              mem_wen,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic              wb_wen,
    output logic [1:0]        fwd_a_sel,
    output logic [1:0]        fwd_b_sel,
    output logic              pc_hold,
    output logic              idex_flush,
    output logic [REG_AW-1:0] idex_dst_d,
    output logic              idex_wen_d,
    output logic              idex_load_d
);
    localparam int N_OPND = 2;

    dec_t dec;
    reg_t opnd_src  [N_OPND];
    logic opnd_used [N_OPND];
    fwd_e opnd_sel  [N_OPND];
    logic opnd_lhit [N_OPND];
    hz_t  hz_d;

    id_field_decode u_dec (
        .instr (id_instr),
        .dec   (dec)
    );

    assign opnd_src[0]  = dec.s1;
    assign opnd_src[1]  = dec.s2;
    assign opnd_used[0] = dec.u1;
    assign opnd_used[1] = dec.u2;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        operand_bypass_pick u_pick (
            .src      (opnd_src[g]),
            .used     (opnd_used[g]),
            .ex_dst   (ex_dst),
            .ex_wen   (ex_wen),
            .ex_load  (ex_load),
            .mem_dst  (mem_dst),
            .mem_wen  (mem_wen),
            .wb_dst   (wb_dst),
            .wb_wen   (wb_wen),
            .sel      (opnd_sel[g]),
            .load_hit (opnd_lhit[g])
        );
    end

    always_comb begin
        hz_d       = '0;
        hz_d.stall = opnd_lhit[0] | opnd_lhit[1];
        if (!hz_d.stall) begin
            hz_d.sel_a = opnd_sel[0];
            hz_d.sel_b = opnd_sel[1];
            hz_d.dst   = dec.wen ? dec.dst : '0;
            hz_d.wen   = dec.wen;
            hz_d.load  = dec.load;
        end
    end

    assign fwd_a_sel   = hz_d.sel_a;
    assign fwd_b_sel   = hz_d.sel_b;
    assign pc_hold     = hz_d.stall;
    assign idex_flush  = hz_d.stall;
    assign idex_dst_d  = hz_d.dst;
    assign idex_wen_d  = hz_d.wen;
    assign idex_load_d = hz_d.load;
endmodule

// File: rtl/hazard_interlock_chk.sv
module hazard_interlock_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] id_instr,
    input logic [4:0]  ex_dst,
    input logic        ex_wen,
    input logic        ex_load,
    input logic [1:0]  fwd_a_sel,
    input logic [1:0]  fwd_b_sel,
    input logic        pc_hold,
    input logic        idex_flush,
    input logic        idex_wen_d,
    input logic        idex_load_d,
    input logic [4:0]  idex_dst_d
);
    assert_hold_needs_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (ex_load && ex_wen && ex_dst != 5'd0));

    assert_flush_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        idex_flush |-> (!idex_wen_d && !idex_load_d && idex_dst_d == 5'd0
                        && fwd_a_sel == 2'd0 && fwd_b_sel == 2'd0));

    assert_zero_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (id_instr[25:21] == 5'd0) |-> (fwd_a_sel == 2'd0));

    assert_ex_pick_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a_sel == 2'd1) |-> (ex_wen && ex_dst == id_instr[25:21]));

    assert_jump_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_instr[31:27] == 5'b00001) |-> (!pc_hold && fwd_a_sel == 2'd0 && fwd_b_sel == 2'd0));

    assert_no_load_no_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_load |-> !pc_hold);
endmodule

bind hazard_interlock hazard_interlock_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_instr    (id_instr),
    .ex_dst      (ex_dst),
    .ex_wen      (ex_wen),
    .ex_load     (ex_load),
    .fwd_a_sel   (fwd_a_sel),
    .fwd_b_sel   (fwd_b_sel),
    .pc_hold     (pc_hold),
    .idex_flush  (idex_flush),
    .idex_wen_d  (idex_wen_d),
    .idex_load_d (idex_load_d),
    .idex_dst_d  (idex_dst_d)
);

// File: tb/tb_hazard_interlock.sv
module tb_hazard_interlock;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] id_instr = '0;
    logic [4:0]  ex_dst = '0, mem_dst = '0, wb_dst = '0;
    logic        ex_wen = 1'b0, ex_load = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
    logic [1:0]  fwd_a_sel, fwd_b_sel;
    logic        pc_hold, idex_flush, idex_wen_d, idex_load_d;
    logic [4:0]  idex_dst_d;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_interlock dut (
        .clk(clk), .rst_n(rst_n), .id_instr(id_instr),
        .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
        .mem_dst(mem_dst), .mem_wen(mem_wen), .wb_dst(wb_dst), .wb_wen(wb_wen),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .pc_hold(pc_hold),
        .idex_flush(idex_flush), .idex_dst_d(idex_dst_d),
        .idex_wen_d(idex_wen_d), .idex_load_d(idex_load_d)
    );

    function automatic logic [31:0] rr(input logic [4:0] s, t, d);
        return {6'h00, s, t, d, 11'h020};
    endfunction
    function automatic logic [31:0] ld(input logic [4:0] s, d);
        return {6'h23, s, d, 16'h0004};
    endfunction
    function automatic logic [31:0] st(input logic [4:0] s, t);
        return {6'h2B, s, t, 16'h0008};
    endfunction
    function automatic logic [31:0] ai(input logic [4:0] s, d);
        return {6'h08, s, d, 16'h0010};
    endfunction
    function automatic logic [31:0] bq(input logic [4:0] s, t);
        return {6'h04, s, t, 16'h0003};
    endfunction

    typedef struct packed {
        logic [31:0] ins;
        logic [4:0]  exd;  logic exw; logic exl;
        logic [4:0]  md;   logic mw;
        logic [4:0]  wd;   logic ww;
        logic [1:0]  ea;   logic [1:0] eb; logic es;
        logic [4:0]  edst; logic ew; logic el;
        logic [7:0]  req;
    } vec_t;

    // expected: {sel_a, sel_b, stall, dst, wen, load}
    localparam vec_t VEC [N_VEC] = '{
        '{rr(1,2,3),  1,1,0, 0,0, 0,0, 1,0,0, 3,1,0, 3},   // R3 ex match
        '{rr(1,2,3),  0,0,0, 2,1, 0,0, 0,2,0, 3,1,0, 3},   // R3 mem match
        '{rr(1,2,3),  0,0,0, 0,0, 1,1, 3,0,0, 3,1,0, 3},   // R3 wb match
        '{rr(4,4,5),  4,1,0, 4,1, 4,1, 1,1,0, 5,1,0, 3},   // R3 ex wins
        '{rr(4,5,6),  0,0,0, 4,1, 4,1, 2,0,0, 6,1,0, 3},   // R3 mem over wb
        '{rr(0,0,7),  0,1,0, 0,1, 0,1, 0,0,0, 7,1,0, 4},   // R4 r0 source
        '{rr(0,1,2),  0,1,1, 0,0, 0,0, 0,0,0, 2,1,0, 4},   // R4 load to r0
        '{rr(1,2,3),  2,1,1, 0,0, 0,0, 0,0,1, 0,0,0, 5},   // R5/R6 load-use B
        '{ld(5,6),    5,1,1, 0,0, 0,0, 0,0,1, 0,0,0, 5},   // R5/R6 load-use A
        '{ai(1,2),    2,1,1, 0,0, 0,0, 0,0,0, 2,1,0, 7},   // R7/R1 imm: bits 20:16 not a source
        '{32'h0BFF_FFFF, 31,1,1, 31,1, 31,1, 0,0,0, 0,0,0, 7}, // R7 jump reads nothing
        '{rr(8,9,10), 0,0,0, 8,1, 0,0, 2,0,0, 10,1,0, 8},  // R8 mem-stage value
        '{rr(1,2,3),  1,0,0, 1,1, 0,0, 2,0,0, 3,1,0, 9},   // R9 ex not writing
        '{rr(1,2,3),  1,0,1, 0,0, 0,0, 0,0,0, 3,1,0, 9},   // R9 non-writing load
        '{st(3,4),    4,1,0, 0,0, 0,0, 0,1,0, 0,0,0, 2},   // R2 store both sources
        '{bq(6,7),    0,0,0, 7,1, 0,0, 0,2,0, 0,0,0, 2},   // R2 branch both sources
        '{ld(9,12),   0,0,0, 0,0, 9,1, 3,0,0, 12,1,1, 10}, // R10 load fields
        '{rr(1,2,0),  0,0,0, 0,0, 0,0, 0,0,0, 0,0,0, 4}    // R4 dest r0
    };

    task automatic apply(input vec_t v);
        @(negedge clk);
        id_instr = v.ins;
        ex_dst = v.exd; ex_wen = v.exw; ex_load = v.exl;
        mem_dst = v.md; mem_wen = v.mw;
        wb_dst = v.wd;  wb_wen = v.ww;
        #1;
    endtask

    task automatic compare(input vec_t v, input string tag);
        logic [11:0] act, exp;
        act = {fwd_a_sel, fwd_b_sel, pc_hold, idex_dst_d, idex_wen_d, idex_load_d};
        exp = {v.ea, v.eb, v.es, v.edst, v.ew, v.el};
        checks++;
        if (act !== exp || idex_flush !== v.es) begin
            errors++;
            $display("FAIL %s: actual a/b/hold/dst/wen/ld=%h flush=%b expected=%h flush=%b",
                     tag, act, idex_flush, exp, v.es);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        vec_t v;
        repeat (3) @(posedge clk);
        // reset state with an all-zero word in decode (R4, R6)
        v = '{32'h0, 0,0,0, 0,0, 0,0, 0,0,0, 0,0,0, 4};
        apply(v);
        compare(v, "R4 reset nop");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < N_VEC; i++) begin
            apply(VEC[i]);
            compare(VEC[i], $sformatf("R%0d vec%0d", VEC[i].req, i));
        end

        // R8 sequence: load-use holds once, then mem/wb bypass takes over
        v = '{rr(2,3,4), 2,1,1, 0,0, 0,0, 0,0,1, 0,0,0, 5};
        apply(v);
        compare(v, "R5 load-use first cycle");
        v = '{rr(2,3,4), 0,0,0, 2,1, 0,0, 2,0,0, 4,1,0, 8};
        apply(v);
        compare(v, "R8 after one stall");

        // R1 field position: same register in bits 15:11 of rr is not a source
        v = '{rr(1,2,9), 9,1,1, 0,0, 0,0, 0,0,0, 9,1,0, 1};
        apply(v);
        compare(v, "R1 dest field not a source");

        // R10 immediate destination from bits 20:16
        v = '{ai(3,14), 0,0,0, 0,0, 0,0, 0,0,0, 14,1,0, 10};
        apply(v);
        compare(v, "R10 imm dest");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule